// File: doc/BRIEF.md
# Secure boot controller register bank

A word-indexed register bank occupying a 4 KiB window on a simple 32-bit peripheral bus. Software reaches it with a one-cycle request carrying a byte address, a write enable, write data and byte strobes; read data comes back on a registered output. The byte address is shifted right by two to pick a 32-bit word, so the two lowest address bits do not select anything.

Most words, including the protection word at byte offset 0x000, are ordinary read/write storage that clears to zero on reset. Two words are fixed after reset and ignore software writes. The boot status word sits at 0x014. The signing configuration word sits at 0x040; bits 13:12 of it carry the RSA mode and bits 11:10 the hash mode. Their reset contents come from two elaboration parameters that act like straps: an eMMC alternate-boot enable and a 32-bit signing settings word. Accesses beyond the implemented word count read as zero and write nothing. A one-cycle error pulse flags those accesses and any attempt to write a fixed word.

Top module: `sbc_regbank`

## Requirements
- R1: After reset every word other than the status and signing words reads 0x00000000, including the protection word at 0x000.
- R2: After reset the status word (0x014) reads bit 2 and bit 1 set; bit 14 is set when parameter EMMC_ALT_BOOT is 1, bit 6 is set when SIGN_SETTINGS is nonzero, and all other bits are 0.
- R3: After reset the signing word (0x040) reads the value of SIGN_SETTINGS, so its bits 13:12 (RSA mode) and 11:10 (hash mode) follow that parameter.
- R4: A write with strobes 4'b1111 to a writable in-range word stores all 32 bits, and a later read of that word returns them. This includes the last implemented word, index NUM_REGS-1.
- R5: Byte strobes are little-endian: strb[i] set updates bits 8i+7:8i of the word, and bytes whose strobe is clear keep their value.
- R6: Writes to the status and signing words leave them unchanged.
- R7: A read whose word index is NUM_REGS or more returns 0. A write to such an index changes no register and does not alias onto a lower index.
- R8: Read data appears on rdata at the first clock edge after the read request. rdata holds its value in every cycle without a read, including write cycles.
- R9: err is high for exactly the cycle after a request that is out of range or that writes a fixed word. It stays low after in-range reads (including reads of fixed words), after in-range writable writes, and while idle.
- R10: Byte address bits 1:0 are ignored when a word is selected, so 0x006 addresses word 1 and 0x043 addresses the signing word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address within the window |
| wdata | input | 32 | Write data |
| strb | input | 4 | Byte strobes, bit i covers byte i |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle error pulse |

## Verification
The bench builds two instances from the same bus. The first uses EMMC_ALT_BOOT=1 and SIGN_SETTINGS=0x00003400, which sets both optional status bits (status 0x4046) and puts nonzero RSA and hash fields in the signing word. The second uses the defaults, so status reads 0x0006 and the signing word reads zero. Both instances keep NUM_REGS=256. With that count, index 255 is the last writable word and byte address 0x400 is the first out-of-range index. A write to 0x400 would land on word 0 if the range check were missing, so the bench can see whether the write aliases.

// File: rtl/sbc_regbank.sv
module sbc_regbank #(
  parameter int          NUM_REGS      = 256,
  parameter int          ADDR_W        = 12,
  parameter int          STATUS_IDX    = 5,
  parameter int          SIGN_IDX      = 16,
  parameter bit          EMMC_ALT_BOOT = 1'b0,
  parameter logic [31:0] SIGN_SETTINGS = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        strb,
  output logic [31:0]       rdata,
  output logic              err
);
  localparam int          WORD_W = ADDR_W - 2;
  localparam int          IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [31:0] NREG   = NUM_REGS;
  localparam logic [31:0] STATUS_RST = 32'h0000_0006
                                     | (EMMC_ALT_BOOT ? 32'h0000_4000 : 32'h0)
                                     | ((SIGN_SETTINGS != 32'h0) ? 32'h0000_0040 : 32'h0);

  logic [31:0] regs [NUM_REGS];

  wire [WORD_W-1:0] idx      = addr[ADDR_W-1:2];
  wire [IDX_W-1:0]  slot     = IDX_W'(idx);
  wire              in_range = (32'(idx) < NREG);
  wire              fixed    = (32'(idx) == STATUS_IDX) || (32'(idx) == SIGN_IDX);
  wire              wr_ok    = req && we && in_range && !fixed;
  wire              rd_go    = req && !we;
  wire              bad      = req && (!in_range || (we && fixed));
  wire              unused_ok = &{1'b0, addr[1:0]};

  function automatic logic [31:0] reset_word(int i);
    if (i == STATUS_IDX)    return STATUS_RST;
    else if (i == SIGN_IDX) return SIGN_SETTINGS;
    else                    return 32'h0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reset_word(i);
    end else if (wr_ok) begin
      for (int b = 0; b < 4; b++)
        if (strb[b]) regs[slot][8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= 32'h0;
      err   <= 1'b0;
    end else begin
      err <= bad;
      if (rd_go) rdata <= in_range ? regs[slot] : 32'h0;
    end
  end

  p_status_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we) |=> $stable(regs[STATUS_IDX]));

  p_sign_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we) |=> $stable(regs[SIGN_IDX]));

  p_oob_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && !in_range) |=> (rdata == 32'h0));

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> $stable(rdata));

  p_err_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req));

  p_err_on_fixed_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && fixed) |=> err);
endmodule

// File: tb/sbc_regbank_tb.sv
module sbc_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  strb = '0;
  logic [31:0] rdata, rdata0;
  logic        err, err0;
  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sbc_regbank #(.EMMC_ALT_BOOT(1'b1), .SIGN_SETTINGS(32'h0000_3400)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .strb(strb), .rdata(rdata), .err(err));

  sbc_regbank u_dut0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .strb(strb), .rdata(rdata0), .err(err0));

  typedef struct packed {
    logic        w;
    logic [11:0] a;
    logic [31:0] d;
    logic [3:0]  s;
    logic [31:0] exp;
    logic        eerr;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0,         4'h0, 32'h0,         1'b0, 8'd1},  // R1
    '{1'b0, 12'h008, 32'h0,         4'h0, 32'h0,         1'b0, 8'd1},  // R1
    '{1'b0, 12'h014, 32'h0,         4'h0, 32'h0000_4046, 1'b0, 8'd2},  // R2
    '{1'b0, 12'h040, 32'h0,         4'h0, 32'h0000_3400, 1'b0, 8'd3},  // R3
    '{1'b1, 12'h000, 32'hA5A5_1234, 4'hF, 32'h0,         1'b0, 8'd4},  // R4
    '{1'b0, 12'h000, 32'h0,         4'h0, 32'hA5A5_1234, 1'b0, 8'd4},  // R4
    '{1'b1, 12'h004, 32'h1122_3344, 4'h1, 32'h0,         1'b0, 8'd5},  // R5
    '{1'b0, 12'h004, 32'h0,         4'h0, 32'h0000_0044, 1'b0, 8'd5},  // R5
    '{1'b1, 12'h004, 32'hAABB_CCDD, 4'hC, 32'h0,         1'b0, 8'd5},  // R5
    '{1'b0, 12'h004, 32'h0,         4'h0, 32'hAABB_0044, 1'b0, 8'd5},  // R5
    '{1'b1, 12'h004, 32'h0099_0000, 4'h2, 32'h0,         1'b0, 8'd5},  // R5
    '{1'b0, 12'h004, 32'h0,         4'h0, 32'hAABB_0044, 1'b0, 8'd5},  // R5
    '{1'b1, 12'h014, 32'hFFFF_FFFF, 4'hF, 32'h0,         1'b1, 8'd9},  // R9
    '{1'b0, 12'h014, 32'h0,         4'h0, 32'h0000_4046, 1'b0, 8'd6},  // R6
    '{1'b1, 12'h040, 32'h0,         4'hF, 32'h0,         1'b1, 8'd9},  // R9
    '{1'b0, 12'h040, 32'h0,         4'h0, 32'h0000_3400, 1'b0, 8'd6},  // R6
    '{1'b1, 12'h400, 32'hDEAD_BEEF, 4'hF, 32'h0,         1'b1, 8'd9},  // R9
    '{1'b0, 12'h400, 32'h0,         4'h0, 32'h0,         1'b1, 8'd7},  // R7
    '{1'b0, 12'h000, 32'h0,         4'h0, 32'hA5A5_1234, 1'b0, 8'd7},  // R7
    '{1'b1, 12'hFFC, 32'h0000_0001, 4'hF, 32'h0,         1'b1, 8'd7},  // R7
    '{1'b0, 12'hFFC, 32'h0,         4'h0, 32'h0,         1'b1, 8'd7},  // R7
    '{1'b0, 12'h3FC, 32'h0,         4'h0, 32'h0,         1'b0, 8'd4},  // R4
    '{1'b1, 12'h3FC, 32'h0000_0055, 4'hF, 32'h0,         1'b0, 8'd4},  // R4
    '{1'b0, 12'h3FC, 32'h0,         4'h0, 32'h0000_0055, 1'b0, 8'd4},  // R4
    '{1'b0, 12'h006, 32'h0,         4'h0, 32'hAABB_0044, 1'b0, 8'd10}, // R10
    '{1'b1, 12'h043, 32'h1,         4'hF, 32'h0,         1'b1, 8'd10}  // R10
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(logic w, logic [11:0] a, logic [31:0] d, logic [3:0] s);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; strb = s;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 rdata in reset", rdata, 32'h0);
    chk("R9 err in reset", {31'h0, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    access(1'b0, 12'h014, 32'h0, 4'h0);
    chk("R2 default status", rdata0, 32'h0000_0006);
    access(1'b0, 12'h040, 32'h0, 4'h0);
    chk("R3 default signing word", rdata0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].w, VECS[i].a, VECS[i].d, VECS[i].s);
      if (!VECS[i].w)
        chk($sformatf("R%0d rdata vec %0d", VECS[i].tag, i), rdata, VECS[i].exp);
      chk($sformatf("R%0d err vec %0d", VECS[i].tag, i), {31'h0, err}, {31'h0, VECS[i].eerr});
    end

    access(1'b0, 12'h000, 32'h0, 4'h0);
    @(negedge clk);
    chk("R9 err drops after one cycle", {31'h0, err}, 32'h0);
    chk("R8 rdata holds while idle", rdata, 32'hA5A5_1234);
    access(1'b1, 12'h000, 32'h1234_5678, 4'hF);
    chk("R8 rdata holds on write", rdata, 32'hA5A5_1234);
    access(1'b0, 12'h000, 32'h0, 4'h0);
    chk("R4 overwrite word 0", rdata, 32'h1234_5678);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 12'h000, 32'h0, 4'h0);
    chk("R1 protection word clears on reset", rdata, 32'h0);
    access(1'b0, 12'h004, 32'h0, 4'h0);
    chk("R1 word 1 clears on reset", rdata, 32'h0);
    access(1'b0, 12'h014, 32'h0, 4'h0);
    chk("R2 status after second reset", rdata, 32'h0000_4046);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule